// File: doc/BRIEF.md
# Move-Only Instruction Decoder

This block decodes one 64-bit instruction for a machine whose only operation is a data move. The instruction is eight bytes, with byte 0 in bits 7:0 and byte 7 in bits 63:56. No opcode field exists. Two fixed framing bytes bracket the word. The destination and source operand-type bytes alone select which move is done. The source type byte sits in byte 2 when the destination is a register, and in byte 6 otherwise.

The block checks the framing and classifies both operand types. It extracts register indices, a 32-bit immediate or absolute address, and any base-register-plus-24-bit-offset fields. It produces a size, an add/subtract flag and load/store direction flags for the execution stage. Illegal combinations raise an I/O exception with a cause code.

An instruction is accepted when `in_valid_i` and `in_ready_o` are both high on a clock edge. The result appears one cycle later as either a `valid_o` pulse or an `exc_o` pulse. A new instruction can be accepted on every cycle.

Top module: `mv_decoder`

## Requirements
- R1: Byte 0 must be 0xF0 and byte 7 must be 0x0F. Any other value in either byte gives an exception with cause 1.
- R2: Type code meanings:
  - 0x04..0x20 is a register, kind 0.
  - 0x00 is an immediate, kind 1.
  - 0x01/0x02/0x03 are an absolute address, kind 2.
  - 0x21..0x23 are register plus offset, kind 3.
  - 0x24..0x26 are register minus offset, kind 4.
  - 0x27 and above are undefined and give cause 2, whether in the destination or in the selected source byte.
- R3: Every register output is the 5-bit index equal to the code minus 0x04, so 0x04 gives 0 and 0x20 gives 28.
- R4: When the destination (byte 1) is a register, byte 2 is the source type. For an immediate or absolute source, bytes 3..6 are taken little-endian into `addr_o`. For a register-relative source, byte 3 is the base register and bytes 4..6 are taken little-endian into `offset_o`. A memory source sets `mem_en_o` with `store_o` low.
- R5: When the destination is memory, the source type is byte 6 and must be a register. For an absolute destination, bytes 2..5 are taken little-endian into `addr_o`. For a relative destination, byte 2 is the base register and bytes 3..5 are the offset. `mem_en_o` and `store_o` are both high.
- R6: `size_o` is 1, 2 or 4 for the byte, word or dword form of a memory type (codes 0x01/0x21/0x24, 0x02/0x22/0x25, 0x03/0x23/0x26), and 0 when no memory is accessed. `sub_o` is high only for codes 0x24..0x26.
- R7: An immediate destination gives cause 3.
- R8: A memory destination with a memory source gives cause 4. A memory destination with an immediate source gives cause 5.
- R9: A register-relative operand whose base byte is not a register code gives cause 6.
- R10: When several faults apply, the lowest cause number is reported.
- R11: Unused trailing bytes of a register-to-register move (bytes 3..6) are ignored.
- R12: The result is due one cycle after acceptance. `valid_o` and `exc_o` are never high together, and each is high for one cycle per accepted instruction. On an exception every decoded field is zero.
- R13: `in_ready_o` is low in reset and high from the first clock edge after reset release. With no accepted instruction, neither `valid_o` nor `exc_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Decoder can accept |
| instr_i | input | 64 | Instruction word, byte 0 in bits 7:0 |
| valid_o | output | 1 | One-cycle pulse: legal instruction decoded |
| exc_o | output | 1 | One-cycle pulse: I/O exception |
| exc_cause_o | output | 3 | Exception cause, 0 when legal |
| dst_kind_o | output | 3 | Destination operand kind |
| src_kind_o | output | 3 | Source operand kind |
| dst_reg_o | output | 5 | Destination register index |
| src_reg_o | output | 5 | Source register index |
| base_reg_o | output | 5 | Base register of the relative memory operand |
| addr_o | output | 32 | Immediate value or absolute address |
| offset_o | output | 24 | Relative offset |
| size_o | output | 3 | Memory access size in bytes |
| sub_o | output | 1 | Offset is subtracted |
| mem_en_o | output | 1 | Move touches memory |
| store_o | output | 1 | Memory is the destination |

## Verification
Every decoded field, the cause code and the `valid_o` or `exc_o` pulse are due in the cycle after the accepting edge. The bench drives on falling edges, so it samples them at the next falling edge. It checks one falling edge later that the pulse has dropped. Back-to-back instructions are checked on consecutive falling edges. `in_ready_o` is checked at a falling edge inside reset and at the falling edge after the first rising edge that follows release.

// File: rtl/mv_dec_pkg.sv
package mv_dec_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned N_BYTES   = 8;
  localparam int unsigned INSTR_W   = BYTE_W * N_BYTES;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned OFF_W     = 24;
  localparam int unsigned SIZE_W    = 3;
  localparam int unsigned KIND_W    = 3;
  localparam int unsigned CAUSE_W   = 3;
  localparam int unsigned N_TYPES   = 3;  // type byte candidates: 1, 2, 6

  localparam logic [BYTE_W-1:0] HEAD_BYTE = 8'hF0;
  localparam logic [BYTE_W-1:0] TAIL_BYTE = 8'h0F;
  localparam logic [BYTE_W-1:0] REG_FIRST = 8'h04;
  localparam logic [BYTE_W-1:0] REG_LAST  = 8'h20;
  localparam logic [BYTE_W-1:0] CODE_IMM  = 8'h00;
  localparam logic [BYTE_W-1:0] ABS_FIRST = 8'h01;
  localparam logic [BYTE_W-1:0] ADD_FIRST = 8'h21;
  localparam logic [BYTE_W-1:0] SUB_FIRST = 8'h24;
  localparam logic [BYTE_W-1:0] CODE_TOP  = 8'h26;

  typedef enum logic [KIND_W-1:0] {
    K_REG  = 3'd0,
    K_IMM  = 3'd1,
    K_ABS  = 3'd2,
    K_RADD = 3'd3,
    K_RSUB = 3'd4,
    K_UNDF = 3'd7
  } kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE     = 3'd0,
    C_FRAME    = 3'd1,
    C_UNDEF    = 3'd2,
    C_DST_IMM  = 3'd3,
    C_MEM_MEM  = 3'd4,
    C_IMM_MEM  = 3'd5,
    C_BAD_BASE = 3'd6
  } cause_e;

  typedef struct packed {
    kind_e             kind;
    logic [SIZE_W-1:0] size;
    logic [REG_W-1:0]  reg_idx;
  } opnd_t;

  typedef struct packed {
    cause_e             cause;
    kind_e              dst_kind;
    kind_e              src_kind;
    logic [REG_W-1:0]   dst_reg;
    logic [REG_W-1:0]   src_reg;
    logic [REG_W-1:0]   base_reg;
    logic [ADDR_W-1:0]  addr;
    logic [OFF_W-1:0]   offset;
    logic [SIZE_W-1:0]  size;
    logic               sub;
    logic               mem_en;
    logic               store;
  } dec_t;

  function automatic logic is_reg_code(logic [BYTE_W-1:0] c);
    return (c >= REG_FIRST) && (c <= REG_LAST);
  endfunction

  function automatic logic is_mem_kind(kind_e k);
    return (k == K_ABS) || (k == K_RADD) || (k == K_RSUB);
  endfunction

  function automatic logic is_rel_kind(kind_e k);
    return (k == K_RADD) || (k == K_RSUB);
  endfunction

  // Wraps correctly for 0x20: 0 - 4 = 28 in 5 bits
  function automatic logic [REG_W-1:0] reg_index(logic [BYTE_W-1:0] c);
    return c[REG_W-1:0] - REG_FIRST[REG_W-1:0];
  endfunction
endpackage

// File: rtl/mv_type_class.sv
module mv_type_class
  import mv_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] code_i,
  output opnd_t             opnd_o
);
  logic [1:0] sz_sel;

  always_comb begin
    opnd_o.kind    = K_UNDF;
    opnd_o.reg_idx = '0;
    sz_sel         = 2'd0;
    if (is_reg_code(code_i)) begin
      opnd_o.kind    = K_REG;
      opnd_o.reg_idx = reg_index(code_i);
    end else if (code_i == CODE_IMM) begin
      opnd_o.kind = K_IMM;
    end else if (code_i < REG_FIRST) begin
      opnd_o.kind = K_ABS;
      sz_sel      = 2'(code_i - ABS_FIRST) + 2'd1;
    end else if (code_i >= ADD_FIRST && code_i < SUB_FIRST) begin
      opnd_o.kind = K_RADD;
      sz_sel      = 2'(code_i - ADD_FIRST) + 2'd1;
    end else if (code_i >= SUB_FIRST && code_i <= CODE_TOP) begin
      opnd_o.kind = K_RSUB;
      sz_sel      = 2'(code_i - SUB_FIRST) + 2'd1;
    end
  end

  always_comb begin
    unique case (sz_sel)
      2'd1:    opnd_o.size = SIZE_W'(1);
      2'd2:    opnd_o.size = SIZE_W'(2);
      2'd3:    opnd_o.size = SIZE_W'(4);
      default: opnd_o.size = '0;
    endcase
  end
endmodule

// File: rtl/mv_field_extract.sv
module mv_field_extract
  import mv_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  localparam int unsigned TYPE_POS [N_TYPES] = '{1, 2, 6};

  logic [BYTE_W-1:0] b [N_BYTES];
  opnd_t             cls [N_TYPES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_bytes
    assign b[i] = instr_i[i*BYTE_W +: BYTE_W];
  end

  for (genvar t = 0; t < N_TYPES; t++) begin : g_class
    mv_type_class u_class (
      .code_i (b[TYPE_POS[t]]),
      .opnd_o (cls[t])
    );
  end

  opnd_t             dst, src, memop;
  logic              dst_mem, src_mem, frame_bad, base_bad;
  logic [BYTE_W-1:0] base_byte;
  logic [ADDR_W-1:0] word_lo, word_hi;
  logic [OFF_W-1:0]  off_lo, off_hi;
  cause_e            cause;

  always_comb begin
    dst       = cls[0];
    src       = (cls[0].kind == K_REG) ? cls[1] : cls[2];
    dst_mem   = is_mem_kind(dst.kind);
    src_mem   = is_mem_kind(src.kind);
    memop     = dst_mem ? dst : src;
    frame_bad = (b[0] != HEAD_BYTE) || (b[N_BYTES-1] != TAIL_BYTE);
    // memory operand fields start at byte 2 for a memory destination, else at byte 3
    word_lo   = {b[5], b[4], b[3], b[2]};
    word_hi   = {b[6], b[5], b[4], b[3]};
    off_lo    = {b[5], b[4], b[3]};
    off_hi    = {b[6], b[5], b[4]};
    base_byte = dst_mem ? b[2] : b[3];
    base_bad  = is_rel_kind(memop.kind) && !is_reg_code(base_byte);
  end

  always_comb begin
    if (frame_bad)                                    cause = C_FRAME;
    else if (dst.kind == K_UNDF || src.kind == K_UNDF) cause = C_UNDEF;
    else if (dst.kind == K_IMM)                       cause = C_DST_IMM;
    else if (dst_mem && src_mem)                      cause = C_MEM_MEM;
    else if (dst_mem && src.kind == K_IMM)            cause = C_IMM_MEM;
    else if (base_bad)                                cause = C_BAD_BASE;
    else                                              cause = C_NONE;
  end

  always_comb begin
    dec_o       = '0;
    dec_o.cause = cause;
    if (cause == C_NONE) begin
      dec_o.dst_kind = dst.kind;
      dec_o.src_kind = src.kind;
      dec_o.dst_reg  = (dst.kind == K_REG) ? dst.reg_idx : '0;
      dec_o.src_reg  = (src.kind == K_REG) ? src.reg_idx : '0;
      dec_o.mem_en   = dst_mem || src_mem;
      dec_o.store    = dst_mem;
      dec_o.size     = (dst_mem || src_mem) ? memop.size : '0;
      dec_o.sub      = (memop.kind == K_RSUB);
      if (is_rel_kind(memop.kind)) begin
        dec_o.base_reg = reg_index(base_byte);
        dec_o.offset   = dst_mem ? off_lo : off_hi;
      end
      if (dst.kind == K_ABS)                          dec_o.addr = word_lo;
      else if (src.kind == K_ABS || src.kind == K_IMM) dec_o.addr = word_hi;
    end
  end
endmodule

// File: rtl/mv_decode_stage.sv
module mv_decode_stage
  import mv_dec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  dec_t dec_i,
  output logic valid_o,
  output logic exc_o,
  output dec_t dec_o
);
  logic ready_q, valid_q, exc_q, accept;
  dec_t dec_q;

  assign accept = in_valid_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      dec_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= accept && (dec_i.cause == C_NONE);
      exc_q   <= accept && (dec_i.cause != C_NONE);
      if (accept) dec_q <= dec_i;
    end
  end

  assign in_ready_o = ready_q;
  assign valid_o    = valid_q;
  assign exc_o      = exc_q;
  assign dec_o      = dec_q;

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && exc_o));
  p_resp_after_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || exc_o) |-> $past(in_valid_i && in_ready_o));
  p_ready_holds_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> in_ready_o);
  p_cause_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o |-> dec_o.cause == C_NONE) and (exc_o |-> dec_o.cause != C_NONE));
  p_exc_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (!dec_o.mem_en && !dec_o.store && dec_o.addr == '0 && dec_o.offset == '0));
  p_store_src_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dec_o.store) |-> (dec_o.mem_en && dec_o.src_kind == K_REG));
  p_reg_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dec_o.dst_reg <= 5'd28 && dec_o.src_reg <= 5'd28 && dec_o.base_reg <= 5'd28));
  p_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dec_o.mem_en ? $countones(dec_o.size) == 1 : dec_o.size == '0));
endmodule

// File: rtl/mv_decoder.sv
module mv_decoder
  import mv_dec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [INSTR_W-1:0]  instr_i,
  output logic                valid_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o,
  output logic [KIND_W-1:0]   dst_kind_o,
  output logic [KIND_W-1:0]   src_kind_o,
  output logic [REG_W-1:0]    dst_reg_o,
  output logic [REG_W-1:0]    src_reg_o,
  output logic [REG_W-1:0]    base_reg_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [OFF_W-1:0]    offset_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic                sub_o,
  output logic                mem_en_o,
  output logic                store_o
);
  dec_t dec_comb, dec_reg;

  mv_field_extract u_extract (
    .instr_i (instr_i),
    .dec_o   (dec_comb)
  );

  mv_decode_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .dec_i      (dec_comb),
    .valid_o    (valid_o),
    .exc_o      (exc_o),
    .dec_o      (dec_reg)
  );

  assign exc_cause_o = dec_reg.cause;
  assign dst_kind_o  = dec_reg.dst_kind;
  assign src_kind_o  = dec_reg.src_kind;
  assign dst_reg_o   = dec_reg.dst_reg;
  assign src_reg_o   = dec_reg.src_reg;
  assign base_reg_o  = dec_reg.base_reg;
  assign addr_o      = dec_reg.addr;
  assign offset_o    = dec_reg.offset;
  assign size_o      = dec_reg.size;
  assign sub_o       = dec_reg.sub;
  assign mem_en_o    = dec_reg.mem_en;
  assign store_o     = dec_reg.store;
endmodule

// File: tb/tb_mv_decoder.sv
`timescale 1ns/1ps
module tb_mv_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] instr_i = '0;
  logic        in_ready_o, valid_o, exc_o, sub_o, mem_en_o, store_o;
  logic [2:0]  exc_cause_o, dst_kind_o, src_kind_o, size_o;
  logic [4:0]  dst_reg_o, src_reg_o, base_reg_o;
  logic [31:0] addr_o;
  logic [23:0] offset_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mv_decoder dut (.*);

  function automatic logic [63:0] mk(input logic [7:0] b1, b2, b3, b4, b5, b6);
    return {8'h0F, b6, b5, b4, b3, b2, b1, 8'hF0};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one instruction; returns at the falling edge where the result is due
  task automatic issue(input logic [63:0] w);
    @(negedge clk_i);
    instr_i = w;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic pulse_gone(input string req);
    @(negedge clk_i);
    chk(req, "pulse dropped", {62'd0, valid_o, exc_o}, 64'd0);
  endtask

  task automatic expect_ok(input string req, input logic [2:0] dk, sk, input logic [4:0] dr, sr, br,
                           input logic [31:0] ad, input logic [23:0] off, input logic [2:0] sz,
                           input logic sb, me, st);
    chk(req, "valid/exc", {62'd0, valid_o, exc_o}, 64'd2);
    chk(req, "cause", exc_cause_o, 0);
    chk(req, "kinds", {dst_kind_o, src_kind_o}, {dk, sk});
    chk(req, "regs", {dst_reg_o, src_reg_o, base_reg_o}, {dr, sr, br});
    chk(req, "addr", addr_o, ad);
    chk(req, "offset", offset_o, off);
    chk(req, "size/sub/mem/store", {size_o, sub_o, mem_en_o, store_o}, {sz, sb, me, st});
  endtask

  task automatic expect_exc(input string req, input logic [2:0] cause);
    chk(req, "valid/exc", {62'd0, valid_o, exc_o}, 64'd1);
    chk(req, "cause", exc_cause_o, cause);
    chk(req, "fields zero", {dst_reg_o, src_reg_o, base_reg_o, addr_o, offset_o, size_o, sub_o, mem_en_o, store_o}, 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R13", "ready in reset", in_ready_o, 0);
    chk("R12", "no pulse in reset", {valid_o, exc_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R13", "ready after release", in_ready_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R13", "idle no pulse", {valid_o, exc_o}, 0);
  endtask

  task automatic t_reg_moves;
    issue(mk(8'h04, 8'h05, 0, 0, 0, 0));
    expect_ok("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    pulse_gone("R12");
    issue(mk(8'h20, 8'h13, 8'hAA, 8'h55, 8'hFF, 8'h01));
    expect_ok("R11", 0, 0, 28, 15, 0, 0, 0, 0, 0, 0, 0);
    pulse_gone("R12");
  endtask

  task automatic t_loads;
    issue(mk(8'h04, 8'h00, 8'h00, 8'hA0, 8'hFB, 8'h00));
    expect_ok("R4", 0, 1, 0, 0, 0, 32'h00FBA000, 0, 0, 0, 0, 0);
    issue(mk(8'h06, 8'h01, 8'h78, 8'h56, 8'h34, 8'h12));
    expect_ok("R4", 0, 2, 2, 0, 0, 32'h12345678, 0, 1, 0, 1, 0);
    issue(mk(8'h06, 8'h23, 8'h04, 8'h00, 8'h70, 8'hAC));
    expect_ok("R6", 0, 3, 2, 0, 0, 0, 24'hAC7000, 4, 0, 1, 0);
    issue(mk(8'h1F, 8'h25, 8'h20, 8'h01, 8'h02, 8'h03));
    expect_ok("R6", 0, 4, 27, 0, 28, 0, 24'h030201, 2, 1, 1, 0);
  endtask

  task automatic t_stores;
    issue(mk(8'h03, 8'h00, 8'hC0, 8'h59, 8'h00, 8'h05));
    expect_ok("R5", 2, 0, 0, 1, 0, 32'h0059C000, 0, 4, 0, 1, 1);
    issue(mk(8'h24, 8'h07, 8'h01, 8'h02, 8'h03, 8'h0A));
    expect_ok("R5", 4, 0, 0, 6, 3, 0, 24'h030201, 1, 1, 1, 1);
    issue(mk(8'h22, 8'h05, 8'hEF, 8'hBE, 8'hAD, 8'h04));
    expect_ok("R6", 3, 0, 0, 0, 1, 0, 24'hADBEEF, 2, 0, 1, 1);
  endtask

  task automatic t_exceptions;
    issue(mk(8'h04, 8'h05, 0, 0, 0, 0) ^ 64'h1);
    expect_exc("R1", 1);
    pulse_gone("R12");
    issue(mk(8'h04, 8'h05, 0, 0, 0, 0) & ~(64'hFF << 56));
    expect_exc("R1", 1);
    issue(mk(8'h27, 8'h05, 0, 0, 0, 8'h05));
    expect_exc("R2", 2);
    issue(mk(8'h04, 8'hFF, 0, 0, 0, 0));
    expect_exc("R2", 2);
    issue(mk(8'h00, 8'h05, 0, 0, 0, 8'h05));
    expect_exc("R7", 3);
    issue(mk(8'h01, 0, 0, 0, 0, 8'h02));
    expect_exc("R8", 4);
    issue(mk(8'h21, 8'h04, 0, 0, 0, 8'h00));
    expect_exc("R8", 5);
    issue(mk(8'h04, 8'h21, 8'h03, 0, 0, 0));
    expect_exc("R9", 6);
    issue(mk(8'h26, 8'h21, 0, 0, 0, 8'h05));
    expect_exc("R9", 6);
    issue(mk(8'h00, 8'h05, 0, 0, 0, 8'h05) ^ 64'h1);
    expect_exc("R10", 1);
    issue(mk(8'h00, 8'h05, 0, 0, 0, 8'h30));
    expect_exc("R10", 2);
    issue(mk(8'h21, 8'h40, 0, 0, 0, 8'h01));
    expect_exc("R10", 4);
    pulse_gone("R12");
  endtask

  task automatic t_back_to_back;
    @(negedge clk_i);
    instr_i = mk(8'h05, 8'h06, 0, 0, 0, 0);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    instr_i = mk(8'h00, 8'h06, 0, 0, 0, 8'h06);
    expect_ok("R12", 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    instr_i = mk(8'h08, 8'h09, 0, 0, 0, 0);
    expect_exc("R12", 3);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    expect_ok("R12", 0, 0, 4, 5, 0, 0, 0, 0, 0, 0, 0);
    pulse_gone("R13");
    @(negedge clk_i);
    chk("R13", "no accept without valid", {valid_o, exc_o}, 0);
  endtask

  initial begin
    t_reset();
    t_reg_moves();
    t_loads();
    t_stores();
    t_exceptions();
    t_back_to_back();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule